// File: doc/BRIEF.md
# Indirect CSR Access Bridge

This bridge lets a host reach a wide internal register space through a small window of host-writable offsets. Offset 0 holds a command word and offset 1 holds a data word. A block of offsets higher in the window acts as a direct range: a write there starts an internal write to a register picked by a fixed map. The bridge turns each accepted host write into one cycle on an internal register bus. That bus carries an address, byte enables, write data and a direction flag, and it uses a request/acknowledge handshake.

A cycle starts in one of three ways:
- A command write with the start flag set and both step flags clear starts a single access.
- A data write starts an access when a step mode (increment or decrement) is active.
- A write to a mapped offset of the direct range starts a write.

In step mode, each completed cycle moves the stored address one register up or down, so a run of data writes fills neighbouring registers. The host polls the busy flag in the command word to see when a cycle has finished. While a cycle is pending, new writes are refused and a sticky error flag is raised.

Top module: `csr_window_bridge`

## Requirements
- R1: After a synchronous active-high reset, the command word reads 0, the data word reads 0, the error flag is 0 and no bus request is raised.
- R2: The command word layout is: busy in bit 31, read-not-write in bit 30, auto-increment in bit 29, auto-decrement in bit 28, byte enables in bits 19:16 and address in bits 15:0. A command write (offset 0) with bit 31 set and bits 29 and 28 clear stores these fields and raises the bus request on the next cycle. The bus then carries the stored address, byte enables and direction, with the current data word as write data.
- R3: From request to acknowledge, the bus address, byte enables, write data and direction stay stable. The cycle after the acknowledge cycle, the request is low and busy reads 0.
- R4: When read-not-write is set, the data word takes the bus read data on the acknowledge cycle.
- R5: With only auto-increment set, a data write (offset 1) stores the data and starts a write cycle, provided read-not-write is clear. Each completed cycle adds 1 to the address.
- R6: With only auto-decrement set, each completed cycle subtracts 1 from the address. The address wraps modulo 2^16 in both directions.
- R7: With both step flags set, a data write still starts a cycle and the address is unchanged after completion.
- R8: A write to direct offset d (window offset 32+d, d in 0..15) is mapped when d mod 4 is not 3. A mapped write loads the data word and sets the address to 0x1000 + 256*(d div 4) + (d mod 4). It sets all four byte enables, clears read-not-write and both step flags, and starts a write cycle.
- R9: A write to an unmapped direct offset is ignored: the command word, the data word and the request are unchanged.
- R10: While busy, writes to offset 0, offset 1 or a mapped direct offset are ignored and set the error flag. The error flag stays set until reset.
- R11: A command write with bit 31 clear, or with a step flag set, only stores fields and starts no cycle. A data write with both step flags clear only stores the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_off | input | WIN_W | Window offset of the host write |
| host_wdata | input | 32 | Host write data |
| cmd_q | output | 32 | Command word readback (busy, direction, step flags, enables, address) |
| data_q | output | 32 | Data word readback |
| err_q | output | 1 | Sticky refused-write flag |
| bus_req | output | 1 | Internal cycle request |
| bus_addr | output | 16 | Internal register address |
| bus_be | output | 4 | Internal byte enables |
| bus_rnw | output | 1 | Internal direction, 1 = read |
| bus_wdata | output | 32 | Internal write data |
| bus_rdata | input | 32 | Internal read data |
| bus_ack | input | 1 | Internal cycle acknowledge |

## Verification
The stored address can go wrong through a wrong step, wrong wrap or wrong direct-range mapping. Such an error shows on `bus_addr` in the very next cycle the bridge requests. It also shows on `cmd_q[15:0]` one cycle after the acknowledge. A busy flag that is stuck or released early shows at once on `bus_req`. It also lets a refused write slip into `data_q` or `cmd_q` at the next clock, and the bench reads both back straight after each refused write. Sweeps over every direct offset and over step chains across both wrap points compare each address against arithmetic computed in the bench.

// File: rtl/csr_window_bridge.sv
module csr_window_bridge #(
  parameter int WIN_W = 6,
  parameter int DIR_BASE = 32,
  parameter int DIR_N = 16,
  parameter logic [15:0] MAP_BASE = 16'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [WIN_W-1:0]  host_off,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       cmd_q,
  output logic [31:0]       data_q,
  output logic              err_q,
  output logic              bus_req,
  output logic [15:0]       bus_addr,
  output logic [3:0]        bus_be,
  output logic              bus_rnw,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack
);
  localparam logic [WIN_W-1:0] OFF_CMD  = '0;
  localparam logic [WIN_W-1:0] OFF_DATA = WIN_W'(1);
  localparam logic [WIN_W-1:0] DIR_LO   = WIN_W'(DIR_BASE);
  localparam logic [WIN_W-1:0] DIR_HI   = WIN_W'(DIR_BASE + DIR_N - 1);

  logic        busy, rnw, inc, dec;
  logic [3:0]  be;
  logic [15:0] addr;
  logic [31:0] data;

  wire win_cmd  = host_we && host_off == OFF_CMD;
  wire win_data = host_we && host_off == OFF_DATA;
  wire dir_hit  = host_we && host_off >= DIR_LO && host_off <= DIR_HI;
  wire [WIN_W-1:0] dir_off = host_off - DIR_LO;
  wire dir_mapped = dir_hit && dir_off[1:0] != 2'b11;
  wire [15:0] map_addr = MAP_BASE + (16'(dir_off[WIN_W-1:2]) << 8) + 16'(dir_off[1:0]);

  wire start_cmd  = host_wdata[31] && !host_wdata[29] && !host_wdata[28];
  wire start_data = (inc || dec) && !rnw;
  wire touch      = win_cmd || win_data || dir_mapped;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; rnw <= 1'b0; inc <= 1'b0; dec <= 1'b0;
      be <= '0; addr <= '0; data <= '0; err_q <= 1'b0;
    end else if (busy) begin
      if (touch) err_q <= 1'b1;
      if (bus_ack) begin
        busy <= 1'b0;
        if (rnw) data <= bus_rdata;
        if (inc && !dec) addr <= addr + 16'd1;
        else if (dec && !inc) addr <= addr - 16'd1;
      end
    end else begin
      if (win_cmd) begin
        rnw  <= host_wdata[30];
        inc  <= host_wdata[29];
        dec  <= host_wdata[28];
        be   <= host_wdata[19:16];
        addr <= host_wdata[15:0];
        busy <= start_cmd;
      end
      if (win_data) begin
        data <= host_wdata;
        busy <= start_data;
      end
      if (dir_mapped) begin
        data <= host_wdata;
        addr <= map_addr;
        be   <= 4'hF;
        rnw  <= 1'b0;
        inc  <= 1'b0;
        dec  <= 1'b0;
        busy <= 1'b1;
      end
    end
  end

  assign cmd_q     = {busy, rnw, inc, dec, 8'h00, be, addr};
  assign data_q    = data;
  assign bus_req   = busy;
  assign bus_addr  = addr;
  assign bus_be    = be;
  assign bus_rnw   = rnw;
  assign bus_wdata = data;

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_be)
                            && $stable(bus_wdata) && $stable(bus_rnw));
  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req && !cmd_q[31]);
  p_read_load_r4: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack && bus_rnw |=> data_q == $past(bus_rdata));
  p_inc_step_r5: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack && cmd_q[29] && !cmd_q[28] |=> bus_addr == $past(bus_addr) + 16'd1);
  p_dec_step_r6: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack && cmd_q[28] && !cmd_q[29] |=> bus_addr == $past(bus_addr) - 16'd1);
  p_both_hold_r7: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack && cmd_q[28] && cmd_q[29] |=> $stable(bus_addr));
  p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_req && dir_hit && !dir_mapped |=> !bus_req && $stable(cmd_q) && $stable(data_q));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  p_busy_refuse_r10: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack && host_we |=> err_q || $stable(data_q));
endmodule

// File: tb/csr_window_bridge_bench.sv
`timescale 1ns/1ps
module csr_window_bridge_bench;
  logic clk = 1'b0, rst = 1'b1, host_we = 1'b0, bus_ack = 1'b0;
  logic [5:0] host_off = '0;
  logic [31:0] host_wdata = '0, bus_rdata = '0;
  logic [31:0] cmd_q, data_q, bus_wdata;
  logic err_q, bus_req, bus_rnw;
  logic [15:0] bus_addr;
  logic [3:0] bus_be;
  int total = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  csr_window_bridge u_csr_window_bridge (
    .clk(clk), .rst(rst), .host_we(host_we), .host_off(host_off),
    .host_wdata(host_wdata), .cmd_q(cmd_q), .data_q(data_q), .err_q(err_q),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_be(bus_be), .bus_rnw(bus_rnw),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [5:0] off, input logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_off = off; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic ack(input logic [31:0] rd);
    @(negedge clk); bus_ack = 1'b1; bus_rdata = rd;
    @(negedge clk); bus_ack = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++; total++;
      $display("FAIL watchdog: actual %0d expected <100000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cmd", cmd_q, 0); chk("R1 data", data_q, 0);
    chk("R1 err", 32'(err_q), 0); chk("R1 req", 32'(bus_req), 0);

    hw(6'd1, 32'hA5A5_0001);
    chk("R11 data only", data_q, 32'hA5A5_0001); chk("R11 no req", 32'(bus_req), 0);
    hw(6'd0, 32'h0003_0123);
    chk("R11 cmd store", cmd_q, 32'h0003_0123); chk("R11 no req cmd", 32'(bus_req), 0);

    hw(6'd0, 32'h800F_0123);
    chk("R2 req", 32'(bus_req), 1); chk("R2 addr", 32'(bus_addr), 32'h0123);
    chk("R2 be", 32'(bus_be), 32'hF); chk("R2 rnw", 32'(bus_rnw), 0);
    chk("R2 wdata", bus_wdata, 32'hA5A5_0001); chk("R2 busy", 32'(cmd_q[31]), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 hold req", 32'(bus_req), 1); chk("R3 hold addr", 32'(bus_addr), 32'h0123);
      chk("R3 hold wdata", bus_wdata, 32'hA5A5_0001);
    end
    ack(32'h0);
    chk("R3 release", 32'(bus_req), 0); chk("R3 busy clear", cmd_q, 32'h000F_0123);

    hw(6'd0, 32'h8003_0300);
    hw(6'd1, 32'hDEAD_BEEF);
    chk("R10 data kept", data_q, 32'hA5A5_0001); chk("R10 err", 32'(err_q), 1);
    hw(6'd0, 32'h800F_0777);
    chk("R10 cmd kept", cmd_q, 32'h8003_0300);
    ack(32'h0);
    chk("R10 sticky", 32'(err_q), 1);

    hw(6'd0, 32'hC00F_0200);
    chk("R4 rnw", 32'(bus_rnw), 1);
    ack(32'h1234_5678);
    chk("R4 read data", data_q, 32'h1234_5678);

    hw(6'd0, 32'h200F_0010);
    chk("R11 auto no start", 32'(bus_req), 0);
    for (int i = 0; i < 8; i++) begin
      hw(6'd1, 32'(i * 32'h11));
      chk("R5 req", 32'(bus_req), 1);
      chk("R5 addr", 32'(bus_addr), 32'(16'h0010 + 16'(i)));
      chk("R5 wdata", bus_wdata, 32'(i * 32'h11));
      ack(32'h0);
      chk("R5 step", 32'(cmd_q[15:0]), 32'(16'h0011 + 16'(i)));
    end

    hw(6'd0, 32'h200F_FFFF); hw(6'd1, 32'h1); ack(32'h0);
    chk("R6 inc wrap", 32'(cmd_q[15:0]), 0);
    hw(6'd0, 32'h100F_0002);
    a = 16'h0002;
    for (int i = 0; i < 4; i++) begin
      hw(6'd1, 32'(i));
      chk("R6 dec addr", 32'(bus_addr), 32'(a));
      ack(32'h0);
      a = a - 16'd1;
      chk("R6 dec step", 32'(cmd_q[15:0]), 32'(a));
    end

    hw(6'd0, 32'h300F_0055); hw(6'd1, 32'h9);
    chk("R7 start", 32'(bus_req), 1);
    ack(32'h0);
    chk("R7 addr kept", 32'(cmd_q[15:0]), 32'h0055);

    hw(6'd0, 32'h2005_0000);
    for (int d = 0; d < 16; d++) begin
      logic [31:0] pc, pd;
      pc = cmd_q; pd = data_q;
      hw(6'(32 + d), 32'hD000 + 32'(d));
      if ((d % 4) != 3) begin
        chk("R8 req", 32'(bus_req), 1);
        chk("R8 addr", 32'(bus_addr), 32'h1000 + 32'((d / 4) * 256 + (d % 4)));
        chk("R8 be", 32'(bus_be), 32'hF); chk("R8 rnw", 32'(bus_rnw), 0);
        chk("R8 wdata", bus_wdata, 32'hD000 + 32'(d));
        chk("R8 steps clear", 32'(cmd_q[29:28]), 0);
        ack(32'h0);
      end else begin
        chk("R9 no req", 32'(bus_req), 0);
        chk("R9 cmd kept", cmd_q, pc); chk("R9 data kept", data_q, pd);
      end
    end

    chk("R10 still set", 32'(err_q), 1);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 err after reset", 32'(err_q), 0); chk("R1 cmd after reset", cmd_q, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule